// File: doc/BRIEF.md
# Write-once security lock latch

This block models a one-time device lock built around a 32-bit key. Software first loads a candidate key into a volatile staging register. A separate program command then copies the staged value into a register that stands in for the nonvolatile cells. Writing the key does not lock anything by itself.

Each time the reset is asserted, the block counts how many cell bits agree with a fixed key pattern. If enough bits agree, it sets a lock flag and holds it. While the flag is set, debug and test access are gated off and the cells can no longer be changed. A read port shows the raw cell contents at all times. An external flash-protection input also refuses writes and commits.

Bits that disagree are tolerated up to a limit, so a few failed cells do not undo a lock. A simulation-only preload path stands in for the arbitrary state of the cells at power-up.

Top module: `wol_lock`

## Requirements
- R1: The fixed key pattern is 32'h50536F43. A cell bit counts as a match when it equals the key bit at the same position.
- R2: `locked` becomes 1 when 28 or more of the 32 cell bits match the key, and 0 otherwise. A pattern with 27 matches gives 0 and a pattern with 28 matches gives 1.
- R3: `locked` is evaluated only on clock edges while `rst_n` is 0, and it holds that value after reset. Committing the key to the cells leaves `locked` unchanged until the next reset.
- R4: `dbg_en` equals `dbg_req` AND NOT `locked`. `test_en` equals `test_req` AND NOT `locked`.
- R5: While the block is not blocked, `wr_en` loads `wr_data` into the staging register on the clock edge. `prog_en` copies the staging register into the cells on the clock edge, so the new value appears on `rd_data` after that edge. If both are high in the same cycle, the commit uses the staging value from before that edge.
- R6: While `flash_prot` is 1, both write and commit requests are refused. The staging register and the cells keep their values.
- R7: While `locked` is 1, both write and commit requests are refused. The cells keep their values.
- R8: `err` is 1 for exactly the one cycle after a refused write or commit request, and 0 at every other time, including during reset.
- R9: `rd_data` always shows the current cell contents, including while the block is locked.
- R10: `preload_en` loads `preload_data` into the cells at any time, whether or not the block is locked. This preload followed by a reset is the only way to clear the lock.
- R11: Reset clears the staging register to 0. A commit right after reset therefore writes 0 to the cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the lock vote is taken while it is low |
| wr_en | input | 1 | Request to load the staging register |
| wr_data | input | 32 | Value for the staging register |
| prog_en | input | 1 | Request to commit the staging register to the cells |
| flash_prot | input | 1 | Flash protection active; refuses write and commit requests |
| dbg_req | input | 1 | Debug access request |
| test_req | input | 1 | Test access request |
| preload_en | input | 1 | Simulation preload strobe for the cells |
| preload_data | input | 32 | Preload value for the cells |
| rd_data | output | 32 | Current cell contents |
| locked | output | 1 | Lock flag taken during reset |
| dbg_en | output | 1 | Debug access granted |
| test_en | output | 1 | Test access granted |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The staging register, the cells and `err` all change on the first clock edge after their request is sampled. `dbg_en` and `test_en` follow their request inputs within the same cycle. `locked` changes only on edges taken while reset is low, and it is checked after reset is released. The bench drives inputs on the falling edge and updates its own model on the rising edge. It then compares every output at the next falling edge, so each result is checked exactly one edge after its cause.

// File: rtl/wol_lock.sv
module wol_lock #(
  parameter int              W      = 32,
  parameter logic [W-1:0]    KEY    = 32'h50536F43,
  parameter int              THRESH = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         prog_en,
  input  logic         flash_prot,
  input  logic         dbg_req,
  input  logic         test_req,
  input  logic         preload_en,
  input  logic [W-1:0] preload_data,
  output logic [W-1:0] rd_data,
  output logic         locked,
  output logic         dbg_en,
  output logic         test_en,
  output logic         err
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  cells;
  logic [W-1:0]  stage;
  logic [CW-1:0] match_cnt;
  logic          lock_q;
  logic          blocked;
  logic          wr_ok;
  logic          prog_ok;
  logic          vote;

  always_comb begin
    match_cnt = '0;
    for (int i = 0; i < W; i++)
      match_cnt = match_cnt + CW'(~(cells[i] ^ KEY[i]));
  end

  assign vote    = (match_cnt >= CW'(THRESH));
  assign blocked = flash_prot | lock_q;
  assign wr_ok   = rst_n & wr_en & ~blocked;
  assign prog_ok = rst_n & prog_en & ~blocked;

  always_ff @(posedge clk) begin
    if (preload_en)   cells <= preload_data;
    else if (prog_ok) cells <= stage;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     stage <= '0;
    else if (wr_ok) stage <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= vote;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= (wr_en | prog_en) & blocked;
  end

  assign rd_data = cells;
  assign locked  = lock_q;
  assign dbg_en  = dbg_req & ~lock_q;
  assign test_en = test_req & ~lock_q;

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(lock_q));

  assert_vote_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lock_q == ($past(match_cnt) >= CW'(THRESH))));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !preload_en) |=> $stable(cells));

  assert_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_prot && !preload_en) |=> $stable(cells) && $stable(stage));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || prog_en));

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (!dbg_en && !test_en));

endmodule

// File: tb/wol_lock_bench.sv
module wol_lock_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] KEY = 32'h50536F43;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, prog_en = 0, flash_prot = 0, dbg_req = 0, test_req = 0, preload_en = 0;
  logic [31:0] wr_data = 0, preload_data = 0;
  logic [31:0] rd_data;
  logic locked, dbg_en, test_en, err;

  int checks = 0, errors = 0;
  logic [31:0] m_cells, m_stage;
  logic m_lock, m_err;

  always #(PERIOD/2) clk = ~clk;

  wol_lock u_wol_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .prog_en(prog_en),
    .flash_prot(flash_prot), .dbg_req(dbg_req), .test_req(test_req),
    .preload_en(preload_en), .preload_data(preload_data), .rd_data(rd_data),
    .locked(locked), .dbg_en(dbg_en), .test_en(test_en), .err(err));

  function automatic logic vote_of(logic [31:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) if (c[i] == KEY[i]) n++;
    return n >= 28;
  endfunction

  function automatic logic [31:0] flip_bits(int k);
    logic [31:0] v = KEY;
    for (int i = 0; i < k; i++) v[i*3 % 32] = ~v[i*3 % 32];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({"R9 rd_data ", tag}, rd_data, m_cells);
    chk({"R2 R3 locked ", tag}, 32'(locked), 32'(m_lock));
    chk({"R8 err ", tag}, 32'(err), 32'(m_err));
    chk({"R4 dbg_en ", tag}, 32'(dbg_en), 32'(dbg_req & ~m_lock));
    chk({"R4 test_en ", tag}, 32'(test_en), 32'(test_req & ~m_lock));
  endtask

  task automatic step(string tag);
    logic blk;
    @(posedge clk);
    blk = flash_prot | m_lock;
    if (!rst_n) begin
      m_lock = vote_of(m_cells);
      m_stage = 0;
      m_err = 0;
      if (preload_en) m_cells = preload_data;
    end else begin
      m_err = (wr_en | prog_en) & blk;
      if (preload_en) m_cells = preload_data;
      else if (prog_en && !blk) m_cells = m_stage;
      if (wr_en && !blk) m_stage = wr_data;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset(logic [31:0] pre, logic use_pre);
    rst_n = 0; wr_en = 0; prog_en = 0;
    preload_en = use_pre; preload_data = pre;
    step("reset");
    preload_en = 0;
    step("reset");
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cells = 0; m_stage = 0; m_lock = 0; m_err = 0;
    @(negedge clk);
    // R11: staging cleared; cells preloaded to 0 (no lock)
    do_reset(32'h0, 1);
    prog_en = 1; step("R11 commit after reset");
    prog_en = 0;
    chk("R11 staging zero", rd_data, 32'h0);

    // R5 write then commit the key; R3 no lock until reset
    wr_en = 1; wr_data = KEY; step("R5 write");
    wr_en = 0; prog_en = 1; step("R5 commit");
    prog_en = 0; step("R3 idle");
    chk("R5 cells hold key", rd_data, KEY);
    chk("R3 not locked before reset", 32'(locked), 32'(0));
    do_reset(0, 0);
    chk("R1 R2 key locks", 32'(locked), 32'(1));
    dbg_req = 1; test_req = 1; step("R4 gate");

    // R7 refused while locked
    wr_en = 1; wr_data = 32'hDEADBEEF; prog_en = 1; step("R7 refused");
    wr_en = 0; prog_en = 0;
    chk("R7 cells kept", rd_data, KEY);
    chk("R8 err high", 32'(err), 32'(1));
    step("R8 err pulse ends");

    // R10 preload unlocks after reset; 27 vs 28 boundary
    do_reset(flip_bits(5), 1);
    chk("R2 27 matches", 32'(locked), 32'(0));
    do_reset(flip_bits(4), 1);
    chk("R2 28 matches", 32'(locked), 32'(1));
    preload_en = 1; preload_data = 32'h0; step("R10 preload while locked");
    preload_en = 0;
    chk("R10 preload visible", rd_data, 32'h0);
    do_reset(0, 0);
    chk("R10 unlocked", 32'(locked), 32'(0));

    // R6 flash protection
    flash_prot = 1; wr_en = 1; wr_data = KEY; prog_en = 1; step("R6 refused");
    wr_en = 0; prog_en = 0; flash_prot = 0;
    prog_en = 1; step("R6 stage kept");
    prog_en = 0;
    chk("R6 stage unchanged", rd_data, 32'h0);

    // R5 same-cycle write and commit uses old stage
    wr_en = 1; wr_data = 32'h12345678; step("R5 load");
    wr_data = 32'hCAFEF00D; prog_en = 1; step("R5 both");
    wr_en = 0; prog_en = 0;
    chk("R5 old stage committed", rd_data, 32'h12345678);

    // random mix
    for (int r = 0; r < 12; r++) begin
      do_reset(flip_bits($urandom_range(0, 8)), 1);
      for (int c = 0; c < 40; c++) begin
        wr_en = $urandom_range(0, 1);
        prog_en = ($urandom_range(0, 3) == 0);
        flash_prot = ($urandom_range(0, 4) == 0);
        dbg_req = $urandom_range(0, 1);
        test_req = $urandom_range(0, 1);
        wr_data = ($urandom_range(0, 1) != 0) ? flip_bits($urandom_range(0, 6)) : $urandom;
        preload_en = ($urandom_range(0, 30) == 0);
        preload_data = $urandom;
        step("random");
      end
      wr_en = 0; prog_en = 0; flash_prot = 0; preload_en = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule